// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes a serial clock and a serial data line, both asynchronous to the system clock, and assembles 8-bit frames. The serial clock is brought into the system domain through a two-flop synchronizer together with the data line. Each detected rising edge of the serial clock shifts one data bit into a shift register, least significant bit first. When the eighth bit arrives, the frame is handed to a data register that the host reads, and a full flag is raised.

The host sees four status flags: data full, overrun, framing error and parity error. The framing and parity flags are set by pulses from a neighbouring character checker. Each flag has its own clear strobe. A frame that completes while the full flag is still set is dropped. The overrun flag is then raised and the buffered byte is kept. Once any error flag is set, the receiver ignores the line. It stays stopped until all three error flags and the full flag read zero again.

Two level interrupt requests, one for data and one for errors, are qualified by a single shared enable input.

Top module: `sync_serial_rx`

## Requirements
- R1: Bits are taken from the synchronized data line on each synchronized rising edge of the serial clock. The first bit lands in bit 0 of the byte and the eighth bit lands in bit 7.
- R2: When a frame completes and the full flag is 0, the byte is copied into the data register and the full flag goes to 1 on the next system clock edge.
- R3: When a frame completes and the full flag is 1, the overrun flag goes to 1. The data register keeps its old byte and the full flag stays at 1.
- R4: While the overrun, framing or parity flag is 1, serial clock edges are ignored and any partly received frame is discarded. After such a stop, reception stays off until the full flag is also 0.
- R5: The data interrupt is high exactly while the enable is 1 and the full flag is 1. The error interrupt is high exactly while the enable is 1 and at least one of the overrun, framing or parity flags is 1.
- R6: A one-cycle high pulse on a flag's clear strobe clears that flag. If a hardware set arrives in the same cycle, the set wins.
- R7: While the receive enable is 0, a partly received frame is discarded. The data register and all flags keep their values.
- R8: If the full flag is cleared before the next frame completes, consecutive frames are all delivered without loss.
- R9: A high pulse on the framing-error or parity-error input sets the matching flag.
- R10: After reset the data register reads 0x00 and all flags and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| irq_en | input | 1 | Shared interrupt enable |
| err_frame_in | input | 1 | Framing error set pulse |
| err_parity_in | input | 1 | Parity error set pulse |
| clr_full | input | 1 | Clear strobe for the full flag |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| clr_fer | input | 1 | Clear strobe for the framing flag |
| clr_per | input | 1 | Clear strobe for the parity flag |
| rd_data | output | 8 | Received data register |
| flag_full | output | 1 | Data full flag |
| flag_ovr | output | 1 | Overrun flag |
| flag_fer | output | 1 | Framing error flag |
| flag_per | output | 1 | Parity error flag |
| irq_rx | output | 1 | Data interrupt request (level) |
| irq_err | output | 1 | Error interrupt request (level) |

## Verification
The bench sends a second frame while the first byte is still unread. A design that copied on overrun would show the new byte, and one that dropped the full flag would show zero. The bench then clears only the overrun flag and sends again. A receiver that restarted too early would deliver that frame instead of holding until the full flag is cleared as well. The bench also drops the receive enable in the middle of a frame, and it pulses a set and a clear on the same flag in the same cycle. Wrong handling shows up as a shifted byte or a lost flag.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic full;
    logic ovr;
    logic fer;
    logic per;
  } srx_flags_t;

  function automatic logic any_error(input srx_flags_t f);
    return f.ovr | f.fer | f.per;
  endfunction

  // Reception is stopped by a live error, or by a past error whose full flag is still up.
  function automatic logic rx_stopped(input srx_flags_t f, input logic hold);
    return any_error(f) | (hold & f.full);
  endfunction
endpackage

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_async,
  input  logic sdata_async,
  output logic sclk_rise,
  output logic sdata_bit
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q    <= '0;
      dt_q    <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_q    <= {ck_q[STAGES-2:0], sclk_async};
      dt_q    <= {dt_q[STAGES-2:0], sdata_async};
      ck_prev <= ck_q[STAGES-1];
    end
  end

  assign sclk_rise = ck_q[STAGES-1] & ~ck_prev;
  assign sdata_bit = dt_q[STAGES-1];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_strobe,
  input  logic              bit_val,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              last_bit;

  // Right shift: newest bit enters at the top, so the first bit ends at bit 0.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur, input logic b);
    return {b, cur[DATA_W-1:1]};
  endfunction

  assign last_bit   = (cnt_q == LAST_IDX);
  assign frame_done = active & bit_strobe & last_bit;
  assign frame_data = shift_in(sh_q, bit_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!active) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (bit_strobe) begin
      sh_q  <= frame_data;
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_status.sv
module srx_status
  import srx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              set_fer,
  input  logic              set_per,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              clr_fer,
  input  logic              clr_per,
  output logic [DATA_W-1:0] data_q,
  output srx_flags_t        flags_q,
  output logic              stopped
);
  logic hold_q;
  logic load_evt;
  logic ovr_evt;

  assign load_evt = frame_done & ~flags_q.full;
  assign ovr_evt  = frame_done &  flags_q.full;
  assign stopped  = rx_stopped(flags_q, hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      flags_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      if (load_evt) data_q <= frame_data;
      flags_q.full <= load_evt | (flags_q.full & ~clr_full);
      flags_q.ovr  <= ovr_evt  | (flags_q.ovr  & ~clr_ovr);
      flags_q.fer  <= set_fer  | (flags_q.fer  & ~clr_fer);
      flags_q.per  <= set_per  | (flags_q.per  & ~clr_per);
      if (any_error(flags_q))  hold_q <= 1'b1;
      else if (!flags_q.full)  hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import srx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              sclk_in,
  input  logic              sdata_in,
  input  logic              irq_en,
  input  logic              err_frame_in,
  input  logic              err_parity_in,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              clr_fer,
  input  logic              clr_per,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag_full,
  output logic              flag_ovr,
  output logic              flag_fer,
  output logic              flag_per,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              evt_bit;
  logic              evt_bit_val;
  logic              evt_frame_done;
  logic [DATA_W-1:0] frame_byte;
  logic              rx_active;
  logic              rx_stop;
  srx_flags_t        flags;

  srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_async  (sclk_in),
    .sdata_async (sdata_in),
    .sclk_rise   (evt_bit),
    .sdata_bit   (evt_bit_val)
  );

  assign rx_active = rx_en & ~rx_stop;

  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (rx_active),
    .bit_strobe (evt_bit),
    .bit_val    (evt_bit_val),
    .frame_done (evt_frame_done),
    .frame_data (frame_byte)
  );

  srx_status #(.DATA_W(DATA_W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (evt_frame_done),
    .frame_data (frame_byte),
    .set_fer    (err_frame_in),
    .set_per    (err_parity_in),
    .clr_full   (clr_full),
    .clr_ovr    (clr_ovr),
    .clr_fer    (clr_fer),
    .clr_per    (clr_per),
    .data_q     (rd_data),
    .flags_q    (flags),
    .stopped    (rx_stop)
  );

  assign flag_full = flags.full;
  assign flag_ovr  = flags.ovr;
  assign flag_fer  = flags.fer;
  assign flag_per  = flags.per;
  assign irq_rx    = irq_en & flags.full;
  assign irq_err   = irq_en & any_error(flags);
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              irq_en,
  input logic              err_frame_in,
  input logic              evt_frame_done,
  input logic [DATA_W-1:0] rd_data,
  input logic              flag_full,
  input logic              flag_ovr,
  input logic              flag_fer,
  input logic              flag_per,
  input logic              irq_err
);
  a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_frame_done && !flag_full) |=> flag_full);

  a_r3_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_frame_done && flag_full) |=> (flag_ovr && flag_full && $stable(rd_data)));

  a_r4_no_frame_when_error: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovr || flag_fer || flag_per) |-> !evt_frame_done);

  a_r7_disable_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !evt_frame_done);

  a_r9_fer_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_in |=> flag_fer);

  a_r5_err_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> irq_en);
endmodule

bind sync_serial_rx sync_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_en          (rx_en),
  .irq_en         (irq_en),
  .err_frame_in   (err_frame_in),
  .evt_frame_done (evt_frame_done),
  .rd_data        (rd_data),
  .flag_full      (flag_full),
  .flag_ovr       (flag_ovr),
  .flag_fer       (flag_fer),
  .flag_per       (flag_per),
  .irq_err        (irq_err)
);

// File: tb/test_sync_serial_rx.sv
`timescale 1ns/1ps
module test_sync_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, sclk_in = 1'b0, sdata_in = 1'b0, irq_en = 1'b0;
  logic err_frame_in = 1'b0, err_parity_in = 1'b0;
  logic clr_full = 1'b0, clr_ovr = 1'b0, clr_fer = 1'b0, clr_per = 1'b0;
  logic [7:0] rd_data;
  logic flag_full, flag_ovr, flag_fer, flag_per, irq_rx, irq_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  sync_serial_rx i_sync_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .irq_en(irq_en), .err_frame_in(err_frame_in), .err_parity_in(err_parity_in),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_fer(clr_fer), .clr_per(clr_per),
    .rd_data(rd_data), .flag_full(flag_full), .flag_ovr(flag_ovr), .flag_fer(flag_fer),
    .flag_per(flag_per), .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // ---------------- behavioural reference ----------------
  int   hist_ck[$] = '{0, 0, 0};
  int   hist_dt[$] = '{0, 0, 0};
  int   m_cnt = 0;
  bit [7:0] m_acc = 0;
  bit [7:0] m_data = 0;
  bit   m_full = 0, m_ovr = 0, m_fer = 0, m_per = 0, m_latch = 0;

  always @(posedge clk) begin : model
    bit edge_seen, done, old_full, old_err;
    if (!rst_n) begin
      hist_ck = '{0, 0, 0}; hist_dt = '{0, 0, 0};
      m_cnt = 0; m_acc = 0; m_data = 0;
      m_full = 0; m_ovr = 0; m_fer = 0; m_per = 0; m_latch = 0;
    end else begin
      edge_seen = (hist_ck[1] == 1) && (hist_ck[2] == 0);
      old_full  = m_full;
      old_err   = m_ovr || m_fer || m_per;
      done = 0;
      if (!rx_en || old_err || (m_latch && old_full)) begin
        m_cnt = 0;
      end else if (edge_seen) begin
        m_acc[m_cnt] = hist_dt[1][0];
        m_cnt++;
        if (m_cnt == 8) begin done = 1; m_cnt = 0; end
      end
      if (done && !old_full) m_data = m_acc;
      m_ovr  = (done && old_full) || (m_ovr && !clr_ovr);
      m_full = (done && !old_full) || (old_full && !clr_full);
      m_fer  = err_frame_in || (m_fer && !clr_fer);
      m_per  = err_parity_in || (m_per && !clr_per);
      if (old_err) m_latch = 1;
      else if (!old_full) m_latch = 0;
      hist_ck.push_front(int'(sclk_in)); void'(hist_ck.pop_back());
      hist_dt.push_front(int'(sdata_in)); void'(hist_dt.pop_back());
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    check(rd_data === m_data, "R1 data", int'(rd_data), int'(m_data));
    check(flag_full === m_full, "R2 full", int'(flag_full), int'(m_full));
    check(flag_ovr === m_ovr, "R3 ovr", int'(flag_ovr), int'(m_ovr));
    check(flag_fer === m_fer, "R9 fer", int'(flag_fer), int'(m_fer));
    check(flag_per === m_per, "R9 per", int'(flag_per), int'(m_per));
    check(irq_rx === (irq_en && m_full), "R5 irq_rx", int'(irq_rx), int'(irq_en && m_full));
    check(irq_err === (irq_en && (m_ovr || m_fer || m_per)), "R5 irq_err",
          int'(irq_err), int'(irq_en && (m_ovr || m_fer || m_per)));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input bit [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sdata_in = b[i]; sclk_in = 1'b0;
      tick(4);
      sclk_in = 1'b1;
      tick(4);
    end
    sclk_in = 1'b0;
    tick(6);
  endtask

  task automatic send_byte(input bit [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_full = 1'b1;
      1: clr_ovr  = 1'b1;
      2: clr_fer  = 1'b1;
      3: clr_per  = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    clr_full = 1'b0; clr_ovr = 1'b0; clr_fer = 1'b0; clr_per = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    tick(3);
    // R10 reset state
    check(rd_data == 8'h00 && !flag_full && !flag_ovr && !irq_rx && !irq_err, "R10 reset",
          int'({flag_full, flag_ovr, flag_fer, flag_per}), 0);
    rst_n = 1'b1; rx_en = 1'b1; irq_en = 1'b1;
    tick(2);

    // R1 R2 R5 first frame
    send_byte(8'hA5);
    check(rd_data == 8'hA5, "R1 lsb-first byte", int'(rd_data), 'hA5);
    check(flag_full == 1'b1, "R2 full set", int'(flag_full), 1);
    check(irq_rx == 1'b1, "R5 data irq", int'(irq_rx), 1);

    // R8 back-to-back with timely clears
    strobe(0); send_byte(8'h3C);
    check(rd_data == 8'h3C, "R8 second frame", int'(rd_data), 'h3C);
    strobe(0); send_byte(8'hC3);
    check(rd_data == 8'hC3 && !flag_ovr, "R8 third frame", int'(rd_data), 'hC3);

    // R3 overrun keeps old byte
    strobe(0); send_byte(8'h11); send_byte(8'h22);
    check(flag_ovr == 1'b1, "R3 ovr set", int'(flag_ovr), 1);
    check(rd_data == 8'h11 && flag_full, "R3 data kept", int'(rd_data), 'h11);
    check(irq_err == 1'b1, "R5 err irq", int'(irq_err), 1);

    // R4 blocked while error, and while full after error
    send_byte(8'h44);
    check(rd_data == 8'h11, "R4 ignored under ovr", int'(rd_data), 'h11);
    strobe(1); send_byte(8'h55);
    check(rd_data == 8'h11 && flag_full, "R4 still stopped until full clear", int'(rd_data), 'h11);
    strobe(0); send_byte(8'h66);
    check(rd_data == 8'h66, "R4 resumes after all clear", int'(rd_data), 'h66);

    // R6 set wins over clear; R9 framing flag blocks
    strobe(0);
    @(negedge clk); err_frame_in = 1'b1; clr_fer = 1'b1;
    @(negedge clk); err_frame_in = 1'b0; clr_fer = 1'b0;
    check(flag_fer == 1'b1, "R6 set beats clear", int'(flag_fer), 1);
    send_byte(8'h77);
    check(!flag_full, "R4 ignored under fer", int'(flag_full), 0);
    strobe(2); send_byte(8'h77);
    check(rd_data == 8'h77, "R9 resume after fer clear", int'(rd_data), 'h77);

    // R9 parity flag, R5 gating off
    irq_en = 1'b0;
    @(negedge clk); err_parity_in = 1'b1;
    @(negedge clk); err_parity_in = 1'b0;
    check(flag_per == 1'b1, "R9 per set", int'(flag_per), 1);
    check(!irq_err && !irq_rx, "R5 gated off", int'({irq_rx, irq_err}), 0);
    strobe(3); strobe(0); irq_en = 1'b1;

    // R7 disable mid-frame discards partial, keeps flags
    send_byte(8'h0F);
    strobe(0);
    send_bits(8'hFF, 3);
    rx_en = 1'b0; tick(4);
    check(rd_data == 8'h0F, "R7 data kept while disabled", int'(rd_data), 'h0F);
    rx_en = 1'b1; tick(2);
    send_byte(8'h96);
    check(rd_data == 8'h96 && !flag_ovr, "R7 partial discarded", int'(rd_data), 'h96);

    tick(10);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule